// File: doc/BRIEF.md
# Instruction Address Sequencer with Circular Return Stack

This block produces the fetch address for a small Harvard-style core. It keeps a 13-bit program counter. Every clock it loads one of six next values: the same address, the address plus one, a branch target, a call target, the interrupt entry address, or an address taken back from an eight-deep hardware return stack. The instruction decoder drives one-hot strobes for advance, jump, call and return, and supplies an 11-bit in-page target. A 2-bit page select input supplies the upper address bits. An interrupt request input comes from an interrupt controller outside this block.

Every redirect (jump, call, return or interrupt entry) raises a flush flag for one cycle. The fetch stage uses it to discard the instruction it prefetched, so a redirected instruction costs two cycles. A parameter gives the size of the memory actually built. Every address the block produces is reduced modulo that size, so a half-size memory wraps around instead of leaving its range. The return stack is not visible to software. It works as a ring: overflow and underflow overwrite or reread entries and raise no error.

Top module: `pcseq`

## Requirements
- R1: While reset is active, and on the first cycles after it is released, the fetch address is 0000h and the flush flag is low.
- R2: With only the advance strobe set and no interrupt pending, the fetch address goes up by one on the next edge. With no strobe set and no interrupt pending, it holds.
- R3: A jump loads the page select bits (2 bits) as address bits 12:11 and the target (11 bits) as bits 10:0. Both are sampled in the cycle of the strobe. A jump leaves the return stack unchanged.
- R4: A call loads its target the same way as a jump and pushes the current fetch address plus one onto the return stack.
- R5: A return loads the most recently pushed entry that has not yet been popped, in last-in first-out order.
- R6: The stack is a ring of 8 entries. A ninth push without a pop overwrites the oldest entry. Popping more entries than were pushed keeps circling round the eight stored entries.
- R7: An interrupt that is taken pushes the current fetch address and loads 0004h. A taken interrupt overrides a simultaneous advance strobe.
- R8: The flush flag is high for exactly the cycle after a jump, call, return or interrupt entry. It is low after an advance or a hold.
- R9: An interrupt request that arrives together with a jump, call or return is remembered. The strobe completes first, and the interrupt is taken on the next cycle that carries none of those strobes, even if the request has dropped by then.
- R10: Every address the block produces is reduced modulo the implemented size IMPL_WORDS (a power of two). With 4096 words, bit 12 is always zero, and advancing past 0FFFh gives 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| adv_i | input | 1 | Advance to the next sequential address |
| jmp_i | input | 1 | Jump strobe |
| call_i | input | 1 | Call strobe (jump and push the return address) |
| ret_i | input | 1 | Return strobe (pop an address) |
| irq_i | input | 1 | Interrupt request, already prioritised |
| tgt_i | input | 11 | In-page branch target from the instruction |
| page_i | input | 2 | Page select bits placed above the target |
| fetch_addr_o | output | 13 | Current fetch address |
| flush_o | output | 1 | Discard the prefetched instruction (redirect in the previous cycle) |

## Verification
The hardest states to reach from the ports are the stack ring limits and an interrupt that is pending at the same moment as a return. Random strobes rarely nest calls nine deep or pop past empty. The stimulus therefore opens with nine back-to-back calls and nine returns, so that one entry is overwritten and the last pop circles back. Directed cycles then set the return and interrupt strobes together, followed by a cycle without the request, and wrap the counter at the top of both an 8K and a 4K instance. Seeded random strobe streams follow, with occasional interrupts, and each edge is compared against a bench reference model.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  // source chosen for the next program counter value
  typedef enum logic [2:0] {
    NS_HOLD = 3'd0,
    NS_INC  = 3'd1,
    NS_JUMP = 3'd2,
    NS_CALL = 3'd3,
    NS_RET  = 3'd4,
    NS_IRQ  = 3'd5
  } nsel_e;
endpackage

// File: rtl/pcseq_stack.sv
module pcseq_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] top_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [PW-1:0] ptr_q, ptr_d, ptr_inc, ptr_dec;
  logic          ptr_en;
  logic [W-1:0]  ent_q [DEPTH];

  always_comb begin
    ptr_inc = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    ptr_dec = (ptr_q == '0) ? LAST : ptr_q - 1'b1;
    ptr_en  = push_i | pop_i;
    ptr_d   = push_i ? ptr_inc : ptr_dec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  // storage entries, each with its own write enable; no reset on data
  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic wen;
    assign wen = push_i && (ptr_q == PW'(e));
    always_ff @(posedge clk) begin
      if (wen) ent_q[e] <= wdata_i;
    end
  end

  assign top_o = ent_q[ptr_dec];
endmodule

// File: rtl/pcseq_ctrl.sv
module pcseq_ctrl
  import pcseq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv_i,
  input  logic  jmp_i,
  input  logic  call_i,
  input  logic  ret_i,
  input  logic  irq_i,
  output nsel_e sel_o,
  output logic  pend_o,
  output logic  flush_d_o
);
  logic branch, irq_want, pend_d, pend_q;

  always_comb begin
    branch    = jmp_i | call_i | ret_i;
    irq_want  = irq_i | pend_q;
    pend_d    = irq_want & branch;
    flush_d_o = branch | irq_want;
    if (jmp_i)         sel_o = NS_JUMP;
    else if (call_i)   sel_o = NS_CALL;
    else if (ret_i)    sel_o = NS_RET;
    else if (irq_want) sel_o = NS_IRQ;
    else if (adv_i)    sel_o = NS_INC;
    else               sel_o = NS_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/pcseq_addr.sv
module pcseq_addr
  import pcseq_pkg::*;
#(
  parameter int PC_W       = 13,
  parameter int PAGE_W     = 2,
  parameter int IMPL_WORDS = 8192,
  parameter int INT_VEC    = 4
) (
  input  nsel_e                    sel_i,
  input  logic [PC_W-1:0]          pc_i,
  input  logic [PAGE_W-1:0]        page_i,
  input  logic [PC_W-PAGE_W-1:0]   tgt_i,
  input  logic [PC_W-1:0]          pop_i,
  output logic [PC_W-1:0]          nxt_o,
  output logic [PC_W-1:0]          push_o
);
  localparam logic [PC_W-1:0] MASK = PC_W'(IMPL_WORDS - 1);
  localparam logic [PC_W-1:0] IVEC = PC_W'(INT_VEC) & MASK;

  logic [PC_W-1:0] inc, br;

  always_comb begin
    inc    = (pc_i + 1'b1) & MASK;
    br     = {page_i, tgt_i} & MASK;
    push_o = (sel_i == NS_CALL) ? inc : pc_i;
    unique case (sel_i)
      NS_INC:  nxt_o = inc;
      NS_JUMP: nxt_o = br;
      NS_CALL: nxt_o = br;
      NS_RET:  nxt_o = pop_i & MASK;
      NS_IRQ:  nxt_o = IVEC;
      default: nxt_o = pc_i;
    endcase
  end
endmodule

// File: rtl/pcseq.sv
module pcseq
  import pcseq_pkg::*;
#(
  parameter int PC_W        = 13,
  parameter int PAGE_W      = 2,
  parameter int STACK_DEPTH = 8,
  parameter int IMPL_WORDS  = 8192,
  parameter int RST_VEC     = 0,
  parameter int INT_VEC     = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   adv_i,
  input  logic                   jmp_i,
  input  logic                   call_i,
  input  logic                   ret_i,
  input  logic                   irq_i,
  input  logic [PC_W-PAGE_W-1:0] tgt_i,
  input  logic [PAGE_W-1:0]      page_i,
  output logic [PC_W-1:0]        fetch_addr_o,
  output logic                   flush_o
);
  localparam logic [PC_W-1:0] MASK = PC_W'(IMPL_WORDS - 1);
  localparam logic [PC_W-1:0] RVEC = PC_W'(RST_VEC) & MASK;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  nsel_e           sel_w;
  logic            pend_w, flush_d;
  logic [PC_W-1:0] pc_q, pc_d, push_data, pop_data;
  logic            pc_en, push_w, pop_w;

  pcseq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .adv_i     (adv_i),
    .jmp_i     (jmp_i),
    .call_i    (call_i),
    .ret_i     (ret_i),
    .irq_i     (irq_i),
    .sel_o     (sel_w),
    .pend_o    (pend_w),
    .flush_d_o (flush_d)
  );

  pcseq_addr #(
    .PC_W       (PC_W),
    .PAGE_W     (PAGE_W),
    .IMPL_WORDS (IMPL_WORDS),
    .INT_VEC    (INT_VEC)
  ) u_addr (
    .sel_i  (sel_w),
    .pc_i   (pc_q),
    .page_i (page_i),
    .tgt_i  (tgt_i),
    .pop_i  (pop_data),
    .nxt_o  (pc_d),
    .push_o (push_data)
  );

  always_comb begin
    push_w = (sel_w == NS_CALL) || (sel_w == NS_IRQ);
    pop_w  = (sel_w == NS_RET);
    pc_en  = (sel_w != NS_HOLD);
  end

  pcseq_stack #(
    .DEPTH (STACK_DEPTH),
    .W     (PC_W)
  ) u_stack (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .push_i  (push_w),
    .pop_i   (pop_w),
    .wdata_i (push_data),
    .top_o   (pop_data)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pc_q    <= RVEC;
      flush_o <= 1'b0;
    end else begin
      if (pc_en) pc_q <= pc_d;
      flush_o <= flush_d;
    end
  end

  assign fetch_addr_o = pc_q;
endmodule

// File: rtl/pcseq_chk.sv
module pcseq_chk
  import pcseq_pkg::*;
#(
  parameter int PC_W       = 13,
  parameter int PAGE_W     = 2,
  parameter int IMPL_WORDS = 8192,
  parameter int INT_VEC    = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   adv_i,
  input logic                   jmp_i,
  input logic                   call_i,
  input logic                   ret_i,
  input logic                   irq_i,
  input logic [PC_W-PAGE_W-1:0] tgt_i,
  input logic [PAGE_W-1:0]      page_i,
  input logic [PC_W-1:0]        fetch_addr_o,
  input logic                   flush_o,
  input nsel_e                  sel,
  input logic                   pend
);
  localparam logic [PC_W-1:0] MASK = PC_W'(IMPL_WORDS - 1);
  localparam logic [PC_W-1:0] IVEC = PC_W'(INT_VEC) & MASK;

  logic quiet, redirect;
  assign quiet    = !jmp_i && !call_i && !ret_i && !irq_i && !pend;
  assign redirect = jmp_i || call_i || ret_i || (sel == NS_IRQ);

  // R10
  in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_addr_o & ~MASK) == '0);

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && !adv_i) |=> $stable(fetch_addr_o));

  // R2
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && adv_i) |=> fetch_addr_o == (($past(fetch_addr_o) + 1'b1) & MASK));

  // R3
  jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jmp_i |=> fetch_addr_o == ({$past(page_i), $past(tgt_i)} & MASK));

  // R7
  irq_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == NS_IRQ) |=> fetch_addr_o == IVEC);

  // R8
  flush_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> flush_o);

  // R8
  flush_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect |=> !flush_o);

  // R9
  irq_deferred_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && irq_i) |=> pend);

  // R9
  pend_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !jmp_i && !call_i && !ret_i) |=> fetch_addr_o == IVEC);
endmodule

bind pcseq pcseq_chk #(
  .PC_W       (PC_W),
  .PAGE_W     (PAGE_W),
  .IMPL_WORDS (IMPL_WORDS),
  .INT_VEC    (INT_VEC)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .adv_i        (adv_i),
  .jmp_i        (jmp_i),
  .call_i       (call_i),
  .ret_i        (ret_i),
  .irq_i        (irq_i),
  .tgt_i        (tgt_i),
  .page_i       (page_i),
  .fetch_addr_o (fetch_addr_o),
  .flush_o      (flush_o),
  .sel          (sel_w),
  .pend         (pend_w)
);

// File: tb/sim_pcseq.sv
module sim_pcseq;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        adv, jmp, call, ret, irq;
  logic [10:0] tgt;
  logic [1:0]  page;
  logic [12:0] fa0, fa1;
  logic        fl0, fl1;

  int nvec = 0;
  int nbad = 0;

  // reference state per instance: 0 = 8K words, 1 = 4K words
  int unsigned mpc   [2];
  int unsigned mptr  [2];
  int unsigned mstk  [2][8];
  bit          mpend [2];
  bit          mfl   [2];
  int unsigned mmask [2];

  pcseq #(.IMPL_WORDS(8192)) u0 (
    .clk(clk), .rst_n(rst_n), .adv_i(adv), .jmp_i(jmp), .call_i(call),
    .ret_i(ret), .irq_i(irq), .tgt_i(tgt), .page_i(page),
    .fetch_addr_o(fa0), .flush_o(fl0));

  pcseq #(.IMPL_WORDS(4096)) u1 (
    .clk(clk), .rst_n(rst_n), .adv_i(adv), .jmp_i(jmp), .call_i(call),
    .ret_i(ret), .irq_i(irq), .tgt_i(tgt), .page_i(page),
    .fetch_addr_o(fa1), .flush_o(fl1));

  task automatic model_step(input int k);
    bit branch, want;
    int unsigned br;
    branch = jmp | call | ret;
    want   = irq | mpend[k];
    br     = {19'd0, page, tgt} & mmask[k];
    mfl[k]   = branch | want;
    mpend[k] = want & branch;
    if (jmp) mpc[k] = br;
    else if (call) begin
      mstk[k][mptr[k]] = (mpc[k] + 1) & mmask[k];
      mptr[k] = (mptr[k] + 1) % 8;
      mpc[k]  = br;
    end else if (ret) begin
      mptr[k] = (mptr[k] + 7) % 8;
      mpc[k]  = mstk[k][mptr[k]];
    end else if (want) begin
      mstk[k][mptr[k]] = mpc[k];
      mptr[k] = (mptr[k] + 1) % 8;
      mpc[k]  = 4;
    end else if (adv) mpc[k] = (mpc[k] + 1) & mmask[k];
  endtask

  task automatic compare(input string req);
    for (int k = 0; k < 2; k++) begin
      logic [12:0] a;
      logic        f;
      a = (k == 0) ? fa0 : fa1;
      f = (k == 0) ? fl0 : fl1;
      nvec++;
      if (a !== 13'(mpc[k]) || f !== mfl[k]) begin
        nbad++;
        $display("FAIL %s inst%0d: addr %h flush %b, expected addr %h flush %b",
                 req, k, a, f, 13'(mpc[k]), mfl[k]);
      end
    end
  endtask

  task automatic step(input bit a, input bit j, input bit c, input bit r,
                      input bit i, input logic [10:0] t, input logic [1:0] p,
                      input string req);
    @(negedge clk);
    adv = a; jmp = j; call = c; ret = r; irq = i; tgt = t; page = p;
    for (int k = 0; k < 2; k++) model_step(k);
    @(posedge clk);
    #1;
    compare(req);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog (all requirements): run still active, expected finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20251));
    mmask[0] = 32'h1FFF;
    mmask[1] = 32'h0FFF;
    for (int k = 0; k < 2; k++) begin
      mpc[k] = 0; mptr[k] = 0; mpend[k] = 1'b0; mfl[k] = 1'b0;
    end
    rst_n = 1'b0;
    adv = 0; jmp = 0; call = 0; ret = 0; irq = 0; tgt = '0; page = '0;
    repeat (3) @(posedge clk);
    #1 compare("R1 in reset");
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 compare("R1 after release");

    // R2 advance and hold
    step(1, 0, 0, 0, 0, '0, '0, "R2 advance");
    step(1, 0, 0, 0, 0, '0, '0, "R2 advance");
    step(0, 0, 0, 0, 0, '0, '0, "R2 hold");
    // R3 paging, R10 4K instance drops bit 12
    step(0, 1, 0, 0, 0, 11'h123, 2'd2, "R3 jump page 2");
    step(1, 0, 0, 0, 0, '0, '0, "R8 flush clears");
    // R4 / R6: nine nested calls, the ninth overwrites the oldest
    for (int n = 0; n < 9; n++)
      step(0, 0, 1, 0, 0, 11'(12'h100 + n * 16), 2'(n), "R4 call push");
    // R5 / R6: nine returns, the last circles back round the ring
    for (int n = 0; n < 9; n++)
      step(0, 0, 0, 1, 0, '0, '0, (n == 8) ? "R6 pop past empty" : "R5 return");
    // R7 interrupt entry overriding advance
    step(1, 0, 0, 0, 1, '0, '0, "R7 interrupt entry");
    step(1, 0, 0, 0, 0, '0, '0, "R2 advance in handler");
    // R9 return and request together: return first, entry next
    step(0, 0, 0, 1, 1, '0, '0, "R9 return with request");
    step(1, 0, 0, 0, 0, '0, '0, "R9 deferred entry");
    step(0, 0, 0, 1, 0, '0, '0, "R5 leave handler");
    // R10 top-of-space wrap for both sizes
    step(0, 1, 0, 0, 0, 11'h7FF, 2'd3, "R10 jump to top");
    step(1, 0, 0, 0, 0, '0, '0, "R10 wrap to zero");
    step(0, 1, 0, 0, 0, 11'h7FF, 2'd1, "R10 jump 0FFFh");
    step(1, 0, 0, 0, 0, '0, '0, "R10 wrap 4K");

    // seeded random strobe streams
    for (int n = 0; n < 4000; n++) begin
      int unsigned r;
      bit a, j, c, q, i;
      r = $urandom % 10;
      a = (r < 4) || (r > 7);
      j = (r == 4);
      c = (r == 5);
      q = (r == 6);
      i = ($urandom % 8) == 0;
      step(a, j, c, q, i, 11'($urandom), 2'($urandom), "R2-R9 random");
    end
    finish_run();
  end
endmodule